// File: doc/BRIEF.md
# Complex Sample to Quadratic-Residue Log-Index Encoder

This block takes one complex two's-complement sample per cycle, with a signed real part and a signed imaginary part, and turns it into the two components of its quadratic residue form for one prime modulus `M`. The prime must satisfy `M ≡ 1 (mod 4)`, so that the congruence `q² + 1 ≡ 0` has two distinct roots. For a root `Q`, the components are `(re + Q·im) mod M` and `(re − Q·im) mod M`.

Each component is then replaced by its discrete logarithm with respect to a primitive root `R`, which is the exponent `w` with `R^w ≡ component (mod M)`. With indices in place of residues, a later constant-coefficient multiplier only has to add indices modulo `M−1`. The block does this conversion once, and every tap of a downstream filter shares the result. A zero component has no logarithm, so the block emits a reserved all-ones code for it.

The block has two pipeline stages: residue formation first, then index lookup. A valid bit travels alongside the data. There is no back-pressure.

Top module: `qrns_index_encoder`

## Requirements
- R1: `outValid` rises exactly two clock cycles after a cycle with `inValid` high, and it is low for every other cycle.
- R2: The first component is `(inReal + Q·inImag) mod M`, taken in the range 0..M−1.
- R3: The second component is `(inReal − Q·inImag) mod M`, taken in the range 0..M−1.
- R4: For a nonzero component `c`, the output index `w` lies in 0..M−2 and satisfies `R^w mod M = c`. `outIdxP` carries the index of the first component and `outIdxM` the index of the second.
- R5: A zero component is emitted as the reserved code with all index bits set (15 for the default `M = 13`, index width 4).
- R6: Negative real or imaginary inputs wrap modulo `M`, so that an input of −1 behaves like `M−1`.
- R7: While `inValid` stays low, `outIdxP` and `outIdxM` keep their last values, whatever the data inputs do.
- R8: While reset is asserted, `outValid` is low and both index outputs hold the reserved zero code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | The sample on the data inputs is valid this cycle |
| inReal | input | DATA_W (10) | Real part, signed |
| inImag | input | DATA_W (10) | Imaginary part, signed |
| outValid | output | 1 | The index outputs hold a new result |
| outIdxP | output | $clog2(M) (4) | Log index of `re + Q·im`, or the zero code |
| outIdxM | output | $clog2(M) (4) | Log index of `re − Q·im`, or the zero code |

## Verification
Three kinds of input are used.

- **Small non-negative pairs.** A grid of every real and imaginary value from 0 to 12 reaches all 169 residue combinations directly, so any wrong entry in the index table shows up.
- **Full real sweep.** A sweep of all 1024 real values, each paired with a scrambled imaginary value, covers large magnitudes and both signs. This separates a correct negative-wrap correction from one that is missing or off by one.
- **Chosen corner pairs.** Pairs such as (−5, 1) and (5, 1) make exactly one component zero, and (0, 0) makes both zero. These show whether the reserved code is applied to each component on its own.

Idle gaps between samples test both the two-cycle latency and the holding of the outputs while nothing is valid.

// File: rtl/qrns_enc_pkg.sv
package qrns_enc_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic ldRes;   // capture residues of the incoming sample
    logic ldIdx;   // capture log indices of the held residues
  } enc_strobe_t;

  // Exponent w in 0..m-2 with r^w = v (mod m); used at elaboration only
  function automatic int unsigned discLog(input int unsigned m,
                                          input int unsigned r,
                                          input int unsigned v);
    int unsigned pw;
    int unsigned found;
    pw    = 1;
    found = 0;
    for (int unsigned w = 0; w < m - 1; w++) begin
      if (pw == v) found = w;
      pw = (pw * r) % m;
    end
    return found;
  endfunction

endpackage

// File: rtl/qrns_enc_ctrl.sv
module qrns_enc_ctrl
  import qrns_enc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  output enc_strobe_t strobe,
  output logic        outValid
);

  logic stage1Valid;
  logic stage2Valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1Valid <= 1'b0;
      stage2Valid <= 1'b0;
    end else begin
      stage1Valid <= inValid;
      stage2Valid <= stage1Valid;
    end
  end

  always_comb begin
    strobe.ldRes = inValid;
    strobe.ldIdx = stage1Valid;
  end

  assign outValid = stage2Valid;

  // R1: a result appears only two cycles after an accepted sample
  p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(inValid, 2));

endmodule

// File: rtl/qrns_enc_datapath.sv
module qrns_enc_datapath
  import qrns_enc_pkg::*;
#(
  parameter int unsigned M      = 13,
  parameter int unsigned Q      = 5,
  parameter int unsigned R      = 2,
  parameter int unsigned DATA_W = 10,
  parameter int unsigned RES_W  = $clog2(M),
  parameter int unsigned IDX_W  = $clog2(M)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  enc_strobe_t       strobe,
  input  logic [DATA_W-1:0] inReal,
  input  logic [DATA_W-1:0] inImag,
  output logic [IDX_W-1:0]  idxP,
  output logic [IDX_W-1:0]  idxM
);

  localparam logic [IDX_W-1:0] ZERO_CODE = '1;
  localparam int               MS        = int'(M);
  localparam int               QM        = int'(Q % M);

  // Reduce a signed sample to 0..M-1, lifting negative remainders
  function automatic int wrapMod(input logic [DATA_W-1:0] raw);
    int t;
    t = int'(signed'(raw)) % MS;
    if (t < 0) t = t + MS;
    return t;
  endfunction

  int               rRe;
  int               rImQ;
  int               sumP;
  int               sumM;
  logic [RES_W-1:0] nextP;
  logic [RES_W-1:0] nextM;
  logic [RES_W-1:0] resP;
  logic [RES_W-1:0] resM;

  always_comb begin
    rRe  = wrapMod(inReal);
    rImQ = (QM * wrapMod(inImag)) % MS;
    sumP = rRe + rImQ;
    if (sumP >= MS) sumP = sumP - MS;
    sumM = rRe + MS - rImQ;
    if (sumM >= MS) sumM = sumM - MS;
    nextP = RES_W'(sumP);
    nextM = RES_W'(sumM);
  end

  // Stage 1: residue registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resP <= '0;
      resM <= '0;
    end else if (strobe.ldRes) begin
      resP <= nextP;
      resM <= nextM;
    end
  end

  // Log table filled from the parameters at elaboration
  logic [IDX_W-1:0] logTbl [M];

  for (genvar v = 0; v < int'(M); v++) begin : g_log
    if (v == 0) begin : g_zero
      assign logTbl[v] = ZERO_CODE;
    end else begin : g_nz
      localparam int unsigned W = discLog(M, R, v);
      assign logTbl[v] = IDX_W'(W);
    end
  end

  // Stage 2: index registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idxP <= ZERO_CODE;
      idxM <= ZERO_CODE;
    end else if (strobe.ldIdx) begin
      idxP <= logTbl[resP];
      idxM <= logTbl[resM];
    end
  end

  // R2 R3: held residues stay inside the ring
  p_res_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(resP) < M) && (32'(resM) < M));

  // R4: a loaded index is a legal exponent or the zero code
  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(idxP) <= M - 2 || idxP == ZERO_CODE) &&
    (32'(idxM) <= M - 2 || idxM == ZERO_CODE));

  // R5: a zero residue turns into the reserved code
  p_zero_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.ldIdx && resP == '0) |=> (idxP == ZERO_CODE));

  // R7: outputs hold while no index load happens
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.ldIdx |=> ($stable(idxP) && $stable(idxM)));

endmodule

// File: rtl/qrns_index_encoder.sv
module qrns_index_encoder
  import qrns_enc_pkg::*;
#(
  parameter int unsigned M      = 13,
  parameter int unsigned Q      = 5,
  parameter int unsigned R      = 2,
  parameter int unsigned DATA_W = 10,
  localparam int unsigned RES_W = $clog2(M),
  localparam int unsigned IDX_W = $clog2(M)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inReal,
  input  logic [DATA_W-1:0] inImag,
  output logic              outValid,
  output logic [IDX_W-1:0]  outIdxP,
  output logic [IDX_W-1:0]  outIdxM
);

  enc_strobe_t strobe;

  qrns_enc_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  qrns_enc_datapath #(
    .M(M), .Q(Q), .R(R), .DATA_W(DATA_W), .RES_W(RES_W), .IDX_W(IDX_W)
  ) i_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .inReal (inReal),
    .inImag (inImag),
    .idxP   (outIdxP),
    .idxM   (outIdxM)
  );

endmodule

// File: tb/test_qrns_index_encoder.sv
module test_qrns_index_encoder;

  localparam int M     = 13;
  localparam int Q     = 5;
  localparam int R     = 2;
  localparam int DW    = 10;
  localparam int IW    = $clog2(M);
  localparam int ZCODE = (1 << IW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inValid = 1'b0;
  logic [DW-1:0] inReal = '0;
  logic [DW-1:0] inImag = '0;
  logic          outValid;
  logic [IW-1:0] outIdxP;
  logic [IW-1:0] outIdxM;

  qrns_index_encoder i_qrns_index_encoder (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReal(inReal),
    .inImag(inImag), .outValid(outValid), .outIdxP(outIdxP), .outIdxM(outIdxM)
  );

  always #10 clk = ~clk;

  typedef struct {
    int p;
    int m;
    int issue;
    bit neg;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   lastP = ZCODE;
  int   lastM = ZCODE;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int wrapRef(int x);
    int t = x % M;
    return (t < 0) ? t + M : t;
  endfunction

  function automatic int logRef(int c);
    int pw = 1;
    if (c == 0) return ZCODE;
    for (int w = 0; w < M - 1; w++) begin
      if (pw == c) return w;
      pw = (pw * R) % M;
    end
    return -1;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", what, act, expv);
    end
  endtask

  task automatic send(input int xr, input int xi);
    exp_t e;
    @(negedge clk);
    inValid = 1'b1;
    inReal  = DW'(xr);
    inImag  = DW'(xi);
    e.p     = logRef(wrapRef(xr + Q * xi));
    e.m     = logRef(wrapRef(xr - Q * xi));
    e.issue = cyc;
    e.neg   = (xr < 0) || (xi < 0);
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      inReal  = DW'(k * 77 + 3);
      inImag  = DW'(k * 51 + 9);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R1 unexpected outValid", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(cyc == e.issue + 2, "R1 latency cycle", cyc, e.issue + 2);
        check(int'(outIdxP) == e.p,
              e.p == ZCODE ? "R5 R2 plus zero code" : (e.neg ? "R6 R2 R4 plus index" : "R2 R4 plus index"),
              int'(outIdxP), e.p);
        check(int'(outIdxM) == e.m,
              e.m == ZCODE ? "R5 R3 minus zero code" : (e.neg ? "R6 R3 R4 minus index" : "R3 R4 minus index"),
              int'(outIdxM), e.m);
        lastP = int'(outIdxP);
        lastM = int'(outIdxM);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R8 outValid in reset", int'(outValid), 0);
    check(int'(outIdxP) == ZCODE, "R8 idxP in reset", int'(outIdxP), ZCODE);
    check(int'(outIdxM) == ZCODE, "R8 idxM in reset", int'(outIdxM), ZCODE);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    check(outValid == 1'b0, "R1 no valid before input", int'(outValid), 0);

    // Corner pairs: zero components and extremes
    send(0, 0);
    send(-5, 1);
    send(5, 1);
    send(-1, 0);
    send(0, -1);
    send(-512, -512);
    send(511, 511);
    send(-512, 511);
    idle(3);

    // All residue combinations from small non-negative pairs
    for (int a = 0; a < M; a++) begin
      for (int b = 0; b < M; b++) begin
        send(a, b);
        if (((a + b) % 7) == 0) idle(1);
      end
    end

    // Full sweep of the real part with a scrambled imaginary part
    for (int xr = -512; xr < 512; xr++) begin
      int xi;
      xi = ((xr * 37 + 11) % 1024 + 1024) % 1024;
      if (xi >= 512) xi = xi - 1024;
      send(xr, xi);
      if ((xr & 31) == 0) idle(2);
    end
    idle(4);
    check(expQ.size() == 0, "R1 scoreboard drained", expQ.size(), 0);

    // R7: data wiggling with inValid low leaves the outputs alone
    idle(6);
    check(outValid == 1'b0, "R7 outValid low when idle", int'(outValid), 0);
    check(int'(outIdxP) == lastP, "R7 idxP held", int'(outIdxP), lastP);
    check(int'(outIdxM) == lastM, "R7 idxM held", int'(outIdxM), lastM);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule